// File: doc/BRIEF.md
# Double-Buffered Dual DAC Register Block

This block sits on a simple byte-wide host bus made of a 3-bit offset, a write strobe, a read strobe and an 8-bit data path in each direction. It drives two 16-bit DAC channels. The host fills a two-byte staging pair for each channel. A second rank of output registers holds the codes that the converters actually see. The same eight-byte window also carries an 8-bit digital output latch and an 8-bit digital input port with no latch.

Each channel's code is straight binary over a 10 V span. Code 0 gives -5 V, code 32768 gives 0 V, and full scale comes close to +5 V. The mode pin selects how the output rank is loaded. In individual mode (0), writing a channel's high byte moves that channel's staged code into its output register. In simultaneous mode (1), high-byte writes only stage data, and the rising edge of any read inside the window loads both output registers together. The bus has no flow control: every strobe completes in the cycle it is sampled, so there is no back-pressure to obey. The staged bytes cannot be read back.

Top module: `dual_dac_regs`

## Requirements
- R1: While reset is asserted and after it is released, both DAC outputs read 16'h8000 and the digital output latch reads 8'h00.
- R2: A write to a low-byte offset (4 for channel 0, 6 for channel 1) stages the byte and leaves both DAC outputs unchanged.
- R3: In individual mode (mode pin 0), a write to a high-byte offset (5 for channel 0, 7 for channel 1) sets that channel's output to {written byte, staged low byte} at the clock edge of the write. The other channel is left unchanged.
- R4: In simultaneous mode (mode pin 1), a high-byte write only stages the byte and changes neither DAC output.
- R5: In simultaneous mode, the rising edge of the read strobe at any offset 0 to 7 loads both outputs from their staged {high, low} bytes at that clock edge.
- R6: A read strobe held high for several cycles causes at most one output update. Data staged while the strobe stays high reaches the outputs only on the next rising edge of the strobe.
- R7: In individual mode, reads at any offset leave both DAC outputs unchanged.
- R8: A write to offset 3 sets all eight bits of the digital output latch at that edge. Bit i of the bus goes to bit i of the latch. The latch holds its value through writes to any other offset.
- R9: While the read strobe is high at offset 3, the read data shows the current digital input pins combinationally, with bit i on bit i, and follows them if they change.
- R10: The read data is zero at every other offset and whenever the read strobe is low.
- R11: The mode pin is sampled only on the clock edge that carries the triggering access. Its value between accesses has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe, update triggered on its rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sync_mode | input | 1 | 0 = individual update, 1 = simultaneous update |
| din_pins | input | 8 | Digital input pins |
| dout_port | output | 8 | Latched digital output port |
| dac0_code | output | 16 | Channel 0 output register |
| dac1_code | output | 16 | Channel 1 output register |

## Verification
A corrupted staging byte stays hidden until the next transfer to the output rank, so it first shows up on the DAC ports one edge after a high-byte write or a read rising edge. The bench therefore checks the outputs right after every such transfer. A stuck read-edge detector shows at the ports in one of two ways: the outputs fail to update on a new strobe, or a held strobe updates them a second time with freshly staged bytes. Decode faults show within a single access, either as the wrong channel or latch changing or as wrong read data in the same cycle.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;
  localparam int BYTE_W   = 8;
  localparam int CODE_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int NUM_CH   = 2;
  localparam int DIO_OFS  = 3;
  localparam int DAC_BASE = 4;

  typedef struct packed {
    logic lo_wr;
    logic hi_wr;
  } ch_strobe_t;
endpackage

// File: rtl/dacbus_decode.sv
module dacbus_decode
  import dacbus_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NCH   = NUM_CH,
  parameter int BASE  = DAC_BASE,
  parameter int DIO_A = DIO_OFS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic             rd,
  output ch_strobe_t       ch_stb [NCH],
  output logic             dio_wr,
  output logic             dio_rd,
  output logic             rd_rise
);
  logic rd_q;

  // Edge detector on the read strobe: one pulse per access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd;
  end

  assign rd_rise = rd & ~rd_q;
  assign dio_wr  = wr & (addr == AW'(DIO_A));
  assign dio_rd  = rd & (addr == AW'(DIO_A));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int LO_A = BASE + 2 * c;
    localparam int HI_A = BASE + 2 * c + 1;
    assign ch_stb[c].lo_wr = wr & (addr == AW'(LO_A));
    assign ch_stb[c].hi_wr = wr & (addr == AW'(HI_A));
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dacbus_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int BW = BYTE_W,
  parameter logic [CW-1:0] RST_CODE = CW'(1) << (CW - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] wdata,
  input  ch_strobe_t    stb,
  input  logic          sync_mode,
  input  logic          rd_rise,
  output logic [CW-1:0] code
);
  localparam int HW = CW - BW;

  logic [BW-1:0] stage_lo;
  logic [HW-1:0] stage_hi;
  logic          load_own;
  logic          load_all;

  assign load_own = stb.hi_wr & ~sync_mode;
  assign load_all = rd_rise & sync_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo <= RST_CODE[BW-1:0];
      stage_hi <= RST_CODE[CW-1:BW];
    end else begin
      if (stb.lo_wr) stage_lo <= wdata;
      if (stb.hi_wr) stage_hi <= wdata[HW-1:0];
    end
  end

  // Second rank: a high-byte write takes the new byte straight through.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code <= RST_CODE;
    else if (load_own) code <= {wdata[HW-1:0], stage_lo};
    else if (load_all) code <= {stage_hi, stage_lo};
  end
endmodule

// File: rtl/dio_port.sv
module dio_port
  import dacbus_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] pins,
  output logic [BW-1:0] latch,
  output logic [BW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  latch <= '0;
    else if (wr) latch <= wdata;
  end

  assign rdata = rd ? pins : '0;
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
  import dacbus_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic                sync_mode,
  input  logic [BYTE_W-1:0]   din_pins,
  output logic [BYTE_W-1:0]   dout_port,
  output logic [CODE_W-1:0]   dac0_code,
  output logic [CODE_W-1:0]   dac1_code
);
  ch_strobe_t        ch_stb [NUM_CH];
  logic              dio_wr;
  logic              dio_rd;
  logic              rd_rise;
  logic [CODE_W-1:0] codes [NUM_CH];

  dacbus_decode #(
    .AW(ADDR_W), .NCH(NUM_CH), .BASE(DAC_BASE), .DIO_A(DIO_OFS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .ch_stb(ch_stb), .dio_wr(dio_wr), .dio_rd(dio_rd), .rd_rise(rd_rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dac
    dac_channel #(.CW(CODE_W), .BW(BYTE_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wdata(bus_wdata), .stb(ch_stb[c]),
      .sync_mode(sync_mode), .rd_rise(rd_rise), .code(codes[c])
    );
  end

  dio_port #(.BW(BYTE_W)) u_dio (
    .clk(clk), .rst_n(rst_n), .wr(dio_wr), .rd(dio_rd), .wdata(bus_wdata),
    .pins(din_pins), .latch(dout_port), .rdata(bus_rdata)
  );

  assign dac0_code = codes[0];
  assign dac1_code = codes[1];
endmodule

// File: rtl/dacbus_checker.sv
module dacbus_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        sync_mode,
  input logic [7:0]  din_pins,
  input logic [7:0]  dout_port,
  input logic [15:0] dac0_code,
  input logic [15:0] dac1_code
);
  logic rd_seen;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 1'b0;
    else        rd_seen <= bus_rd;
  end
  assign rise = bus_rd & ~rd_seen;

  always @(negedge clk) begin
    if (rst_n) begin
      assert_rdata_live_R9: assert (!(bus_rd && bus_addr == 3'd3) || bus_rdata == din_pins);
      assert_rdata_zero_R10: assert ((bus_rd && bus_addr == 3'd3) || bus_rdata == 8'h00);
    end else begin
      assert_reset_vals_R1: assert (dac0_code == 16'h8000 && dac1_code == 16'h8000 && dout_port == 8'h00);
    end
  end

  assert_lo_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[0] && !(rise && sync_mode)) |=> ($stable(dac0_code) && $stable(dac1_code)));

  assert_own_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd5 && !sync_mode) |=> (dac0_code[15:8] == $past(bus_wdata) && $stable(dac1_code)));

  assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sync_mode && !rise) |=> ($stable(dac0_code) && $stable(dac1_code)));

  assert_indiv_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !sync_mode) |=> ($stable(dac0_code) && $stable(dac1_code)));

  assert_held_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rd_seen && !(bus_wr && !sync_mode)) |=> ($stable(dac0_code) && $stable(dac1_code)));

  assert_latch_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3) |=> (dout_port == $past(bus_wdata)));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd3) |=> $stable(dout_port));
endmodule

bind dual_dac_regs dacbus_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .sync_mode(sync_mode), .din_pins(din_pins), .dout_port(dout_port),
  .dac0_code(dac0_code), .dac1_code(dac1_code)
);

// File: tb/tb_dual_dac_regs.sv
module tb_dual_dac_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        sync_mode = 1'b0;
  logic [7:0]  din_pins = '0;
  logic [7:0]  dout_port;
  logic [15:0] dac0_code;
  logic [15:0] dac1_code;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0]  m_lo [2];
  logic [7:0]  m_hi [2];
  logic [15:0] m_out [2];
  logic [7:0]  m_dout;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_dac_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_mode(sync_mode), .din_pins(din_pins), .dout_port(dout_port),
    .dac0_code(dac0_code), .dac1_code(dac1_code)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check({tag, " dac0"}, 32'(dac0_code), 32'(m_out[0]));
    check({tag, " dac1"}, 32'(dac1_code), 32'(m_out[1]));
    check({tag, " dout"}, 32'(dout_port), 32'(m_dout));
  endtask

  // One write cycle; the mode pin is driven only for the strobe cycle.
  task automatic do_write(logic [2:0] a, logic [7:0] d, logic m, logic idle_m);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; sync_mode = m;
    if (a == 3'd3) m_dout = d;
    if (a >= 3'd4) begin
      int ch = (int'(a) - 4) / 2;
      if (a[0]) begin
        m_hi[ch] = d;
        if (!m) m_out[ch] = {d, m_lo[ch]};
      end else begin
        m_lo[ch] = d;
      end
    end
    @(negedge clk);
    bus_wr = 1'b0; sync_mode = idle_m;
  endtask

  task automatic do_read(logic [2:0] a, logic m, logic idle_m, logic [7:0] exp_rd, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; sync_mode = m;
    #1 check(tag, 32'(bus_rdata), 32'(exp_rd));
    if (m) begin
      for (int c = 0; c < 2; c++) m_out[c] = {m_hi[c], m_lo[c]};
    end
    @(negedge clk);
    bus_rd = 1'b0; sync_mode = idle_m;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_lo[c] = 8'h00; m_hi[c] = 8'h80; m_out[c] = 16'h8000;
    end
    m_dout = 8'h00;

    repeat (3) @(negedge clk);
    check_outs("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 after reset");

    // R9: sweep every input pattern at offset 3.
    for (int v = 0; v < 256; v++) begin
      din_pins = 8'(v);
      do_read(3'd3, 1'b0, 1'b0, 8'(v), "R9 din sweep");
    end
    // R9: live value follows pins during one held read.
    @(negedge clk);
    bus_addr = 3'd3; bus_rd = 1'b1; din_pins = 8'h3C;
    #1 check("R9 live a", 32'(bus_rdata), 32'h3C);
    din_pins = 8'hC3;
    #1 check("R9 live b", 32'(bus_rdata), 32'hC3);
    @(negedge clk); bus_rd = 1'b0;

    // R10: every other offset and idle strobe read zero.
    din_pins = 8'hFF;
    for (int a = 0; a < 8; a++) begin
      if (a != 3) do_read(3'(a), 1'b0, 1'b0, 8'h00, "R10 other offset");
    end
    bus_addr = 3'd3;
    #1 check("R10 idle strobe", 32'(bus_rdata), 32'h00);
    check_outs("R7 reads in individual mode");

    // R8: latch sweep, then hold through other writes.
    for (int v = 0; v < 256; v++) begin
      do_write(3'd3, 8'(v ^ 8'h5A), 1'b0, 1'b0);
      check("R8 latch value", 32'(dout_port), 32'(v ^ 8'h5A));
    end
    for (int a = 0; a < 8; a++) begin
      if (a != 3) begin
        do_write(3'(a), 8'(a * 37), 1'b0, 1'b0);
        check_outs("R8 latch held");
      end
    end

    // R2 / R3: individual mode, both channels, many codes.
    for (int i = 0; i < 48; i++) begin
      int ch = i % 2;
      logic [15:0] val = 16'(i * 16'h1F3B) ^ 16'h5A5A;
      do_write(3'(4 + 2 * ch), val[7:0], 1'b0, 1'b0);
      check_outs("R2 low byte only");
      do_write(3'(5 + 2 * ch), val[15:8], 1'b0, 1'b0);
      check(ch == 0 ? "R3 ch0 load" : "R3 ch1 load",
            32'(ch == 0 ? dac0_code : dac1_code), 32'(val));
      check_outs("R3 other channel kept");
    end

    // R7: reads at every offset in individual mode.
    for (int a = 0; a < 8; a++) begin
      do_read(3'(a), 1'b0, 1'b0, (a == 3) ? 8'hFF : 8'h00, "R10 read data");
      check_outs("R7 no update");
    end

    // R4 / R5: simultaneous mode, trigger from every offset.
    for (int a = 0; a < 8; a++) begin
      do_write(3'd4, 8'(a * 17 + 1), 1'b1, 1'b1);
      do_write(3'd5, 8'(a * 29 + 3), 1'b1, 1'b1);
      do_write(3'd6, 8'(a * 41 + 5), 1'b1, 1'b1);
      do_write(3'd7, 8'(a * 53 + 7), 1'b1, 1'b1);
      check_outs("R4 staged only");
      do_read(3'(a), 1'b1, 1'b1, (a == 3) ? 8'hFF : 8'h00, "R10 read data sync");
      check("R5 dac0 loaded", 32'(dac0_code), 32'({8'(a * 29 + 3), 8'(a * 17 + 1)}));
      check("R5 dac1 loaded", 32'(dac1_code), 32'({8'(a * 53 + 7), 8'(a * 41 + 5)}));
    end

    // R6: held read strobe gives one update only.
    do_write(3'd4, 8'h11, 1'b1, 1'b1);
    do_write(3'd5, 8'h22, 1'b1, 1'b1);
    @(negedge clk);
    bus_addr = 3'd0; bus_rd = 1'b1;
    for (int c = 0; c < 2; c++) m_out[c] = {m_hi[c], m_lo[c]};
    @(negedge clk);
    check_outs("R6 first edge");
    bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h99; m_lo[1] = 8'h99;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 3'd1;
    repeat (3) @(negedge clk);
    check_outs("R6 held strobe no second update");
    bus_rd = 1'b0;
    @(negedge clk);
    check_outs("R6 release no update");
    do_read(3'd2, 1'b1, 1'b1, 8'h00, "R10 read data R6");
    check("R6 next edge dac1", 32'(dac1_code), 32'({m_hi[1], 8'h99}));

    // R11: mode only matters on the access edge.
    do_write(3'd4, 8'hAB, 1'b0, 1'b1);
    do_write(3'd5, 8'hCD, 1'b1, 1'b0);
    check_outs("R11 sync at write edge no load");
    do_read(3'd0, 1'b0, 1'b1, 8'h00, "R10 read data R11");
    check_outs("R11 individual at read edge no load");
    do_read(3'd0, 1'b1, 1'b0, 8'h00, "R10 read data R11b");
    check("R11 sync at read edge loads", 32'(dac0_code), 32'h0000CDAB);
    do_write(3'd7, 8'h42, 1'b0, 1'b1);
    check("R11 individual at write edge loads", 32'(dac1_code), 32'({8'h42, m_lo[1]}));

    done = 1;
    report();
    $finish;
  end
endmodule